// File: doc/BRIEF.md
# Dual-Line Serial Converter Readout Engine

This block fetches finished conversion results from an external multichannel converter over a serial link. It drives an active-low chip select and a serial clock. It captures the converter's data-out lines on the falling edge of its own serial clock. Each result is sent to the core side as a 14-bit word tagged with its channel number, on a valid/ready stream.

In dual-line mode, the two data lines are shifted at the same time. Line A carries the lower half of the channels and line B carries the upper half, so the readout takes half as many frames. In single-line mode, all channels come on line A in turn and line B is ignored. During the first frame of each readout, the block watches the converter's first-word marker to confirm word alignment. If the marker is wrong, the block raises a sticky framing error. A stalled consumer pauses the serial clock between frames.

Top module: `dlr_readout`

## Requirements
- R1: After reset, and while no readout runs, `cs_no` is 1, `sclk_o` is 0, `word_valid_o` is 0, `busy_o` is 0 and `frame_err_o` is 0.
- R2: `sclk_o` is 0 whenever `cs_no` is 1. Each high phase of `sclk_o` lasts exactly `HALF` clock cycles, and each low phase lasts at least `HALF` cycles.
- R3: The first `sclk_o` rise comes exactly 2×`HALF` cycles after `cs_no` falls. `cs_no` rises `HALF` cycles after the clock edge that accepts the final word.
- R4: A frame is 16 `sclk_o` periods. A bit is sampled on each falling edge of `sclk_o`. The first 14 bits of a frame form the result, most significant bit first, and the last 2 bits are discarded.
- R5: In dual-line mode (`single_line_i`=0 at start), frame k gives the line A word with channel k and then the line B word with channel k+NUM_CH/2, for k = 0 to NUM_CH/2−1.
- R6: In single-line mode (`single_line_i`=1 at start), frame k gives the line A word with channel k, for k = 0 to NUM_CH−1. `dout_b_i` has no effect on any output.
- R7: While `word_valid_o`=1 and `word_ready_i`=0, the valid flag, `word_data_o` and `word_chan_o` hold their values, and `sclk_o` stays 0.
- R8: In the first frame of a readout, `first_i` must be 1 at the 1st falling-edge sample and 0 at the 15th falling-edge sample. Any other value sets `frame_err_o`. `frame_err_o` then stays set until the next accepted start.
- R9: `start_i` is accepted only while `busy_o`=0. A start request raised while a readout runs, including in the cycle that accepts the final word, does not begin a new readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a full readout |
| single_line_i | input | 1 | 1: all channels on line A; captured when the start is accepted |
| cs_no | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| dout_a_i | input | 1 | Data line A from the converter |
| dout_b_i | input | 1 | Data line B from the converter |
| first_i | input | 1 | First-word marker from the converter |
| word_valid_o | output | 1 | Result word available |
| word_ready_i | input | 1 | Consumer accepts the word |
| word_data_o | output | WBITS | Result word |
| word_chan_o | output | $clog2(NUM_CH) | Channel of the result word |
| busy_o | output | 1 | Readout in progress |
| frame_err_o | output | 1 | Sticky framing error from the last readout |

## Verification
The acceptance of the final word of a readout can fall in the same cycle as a new start request. The bench provokes this by raising `start_i` together with `word_ready_i` on the last handshake. It then judges the result at the ports: `cs_no` must rise after `HALF` cycles and stay high, with no further words. Marker faults are injected by a converter model that either starts the first frame with the marker low or never drops it. Backpressure gaps of several cycles are placed across frame boundaries, to show that data, channel and a quiet `sclk_o` all hold.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_DRAIN, ST_TRAIL} dlr_st_e;
endpackage

// File: rtl/dlr_sclk_div.sv
module dlr_sclk_div #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(HALF - 1);
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= CW'(HALF - 1);
      sclk_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= CW'(HALF - 1);
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // sample strobe: edge on which sclk drops
  assign fall_o = run_i && (cnt_q == '0) && sclk_o;
endmodule

// File: rtl/dlr_lane.sv
module dlr_lane #(
  parameter int WBITS = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             bit_i,
  output logic [WBITS-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (take_i) word_o <= {word_o[WBITS-2:0], bit_i};
  end
endmodule

// File: rtl/dlr_readout.sv
module dlr_readout
  import dlr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WBITS  = 14,
  parameter int FBITS  = 16,
  parameter int HALF   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      single_line_i,
  output logic                      cs_no,
  output logic                      sclk_o,
  input  logic                      dout_a_i,
  input  logic                      dout_b_i,
  input  logic                      first_i,
  output logic                      word_valid_o,
  input  logic                      word_ready_i,
  output logic [WBITS-1:0]          word_data_o,
  output logic [$clog2(NUM_CH)-1:0] word_chan_o,
  output logic                      busy_o,
  output logic                      frame_err_o
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int HALF_CH = NUM_CH / 2;
  localparam int BC_W    = $clog2(FBITS);
  localparam int LC_W    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NLANE   = 2;

  dlr_st_e          st_q;
  logic [LC_W-1:0]  gap_q;
  logic [BC_W-1:0]  bit_q;
  logic [CH_W-1:0]  frame_q;
  logic             sel_q, mode_q, err_q;
  logic             run, fall, take, acc, last_word, last_frame;
  logic [NLANE-1:0] din;
  logic [WBITS-1:0] lane_w [NLANE];

  assign run  = (st_q == ST_SHIFT);
  assign take = fall && (bit_q < BC_W'(WBITS));
  assign din  = {dout_b_i, dout_a_i};

  dlr_sclk_div #(.HALF(HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sclk_o(sclk_o),
    .fall_o(fall)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dlr_lane #(.WBITS(WBITS)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(take),
      .bit_i (din[g]),
      .word_o(lane_w[g])
    );
  end

  assign acc        = word_valid_o && word_ready_i;
  assign last_word  = mode_q || sel_q;
  assign last_frame = mode_q ? (frame_q == CH_W'(NUM_CH - 1))
                             : (frame_q == CH_W'(HALF_CH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      gap_q   <= '0;
      bit_q   <= '0;
      frame_q <= '0;
      sel_q   <= 1'b0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_LEAD;
          gap_q   <= LC_W'(HALF - 1);
          mode_q  <= single_line_i;
          frame_q <= '0;
          sel_q   <= 1'b0;
          bit_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_LEAD: begin
          if (gap_q == '0) st_q <= ST_SHIFT;
          else             gap_q <= gap_q - 1'b1;
        end
        ST_SHIFT: if (fall) begin
          bit_q <= bit_q + 1'b1;
          // marker check in the first frame only
          if (frame_q == '0) begin
            if (bit_q == '0 && !first_i)                err_q <= 1'b1;
            if (bit_q == BC_W'(WBITS) && first_i)       err_q <= 1'b1;
          end
          if (bit_q == BC_W'(FBITS - 1)) begin
            st_q  <= ST_DRAIN;
            bit_q <= '0;
            sel_q <= 1'b0;
          end
        end
        ST_DRAIN: if (acc) begin
          if (!last_word) begin
            sel_q <= 1'b1;
          end else if (last_frame) begin
            st_q  <= ST_TRAIL;
            gap_q <= LC_W'(HALF - 1);
          end else begin
            frame_q <= frame_q + 1'b1;
            st_q    <= ST_SHIFT;
          end
        end
        ST_TRAIL: begin
          if (gap_q == '0) st_q <= ST_IDLE;
          else             gap_q <= gap_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no        = (st_q == ST_IDLE);
  assign busy_o       = (st_q != ST_IDLE);
  assign word_valid_o = (st_q == ST_DRAIN);
  assign word_data_o  = sel_q ? lane_w[1] : lane_w[0];
  assign word_chan_o  = sel_q ? frame_q + CH_W'(HALF_CH) : frame_q;
  assign frame_err_o  = err_q;

  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=>
      word_valid_o && $stable(word_data_o) && $stable(word_chan_o));

  p_quiet_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !sclk_o);

  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && !(cs_no && start_i) |=> frame_err_o);

  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && start_i |=> !cs_no);
endmodule

// File: tb/sim_dlr_readout.sv
module sim_dlr_readout;
  localparam int NUM_CH = 8;
  localparam int WBITS  = 14;
  localparam int HALF   = 4;
  localparam int N_VEC  = 5;
  // [15] single line, [14:12] ready gap, [11:0] seed
  localparam logic [15:0] VEC [N_VEC] = '{
    {1'b0, 3'd0, 12'h0a5}, {1'b0, 3'd2, 12'h3c1}, {1'b1, 3'd0, 12'h777},
    {1'b1, 3'd3, 12'h019}, {1'b0, 3'd1, 12'hbee}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0, ready = 1'b0;
  logic da = 1'b0, db = 1'b0, first_in = 1'b0;
  logic cs_n, sclk, valid, busy, ferr;
  logic [WBITS-1:0] wdata;
  logic [2:0] wchan;

  int checks = 0, errors = 0, fd_mode = 0, fall_cnt = 0, hi_len = 0;
  bit done = 1'b0;
  logic [WBITS-1:0] vals [NUM_CH];

  always #4 clk = ~clk;

  dlr_readout #(.NUM_CH(NUM_CH), .WBITS(WBITS), .FBITS(16), .HALF(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_line_i(single),
    .cs_no(cs_n), .sclk_o(sclk), .dout_a_i(da), .dout_b_i(db), .first_i(first_in),
    .word_valid_o(valid), .word_ready_i(ready), .word_data_o(wdata),
    .word_chan_o(wchan), .busy_o(busy), .frame_err_o(ferr));

  // converter model
  always @(negedge cs_n) begin
    fall_cnt = 0;
    first_in = (fd_mode != 1);
  end
  always @(posedge cs_n) first_in = 1'b0;
  always @(posedge sclk) if (!cs_n) begin
    int fr, b;
    fr = fall_cnt / 16;
    b  = fall_cnt % 16;
    da = (b < 14) ? vals[fr % NUM_CH][13-b] : 1'b0;
    if (single) db = ~da;
    else        db = (b < 14) ? vals[(fr + NUM_CH/2) % NUM_CH][13-b] : 1'b0;
  end
  always @(negedge sclk) if (!cs_n) begin
    fall_cnt++;
    if (fall_cnt == 14 && fd_mode != 2) first_in = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 high-phase width monitor
  always @(negedge clk) if (rst_n) begin
    if (sclk) hi_len++;
    else if (hi_len != 0) begin
      chk(hi_len == HALF, "R2 sclk high phase", hi_len, HALF);
      hi_len = 0;
    end
  end

  task automatic fill(input int seed);
    for (int c = 0; c < NUM_CH; c++)
      vals[c] = WBITS'((seed * 13 + c * 1877 + c * c * 3) ^ (seed << 2));
  endtask

  task automatic kick(input bit sl);
    @(negedge clk);
    single = sl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input bit sl, input int gap, input bit start_last);
    int nw;
    nw = sl ? NUM_CH : NUM_CH;
    for (int k = 0; k < nw; k++) begin
      int ec, w;
      ec = sl ? k : ((k % 2) ? k / 2 + NUM_CH / 2 : k / 2);
      w = 0;
      while (!valid && w < 4000) begin @(negedge clk); w++; end
      chk(wchan == 3'(ec), sl ? "R6 channel order" : "R5 channel order", wchan, ec);
      chk(wdata == vals[ec], "R4 captured word", wdata, vals[ec]);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(valid && wdata == vals[ec] && wchan == 3'(ec) && !sclk,
            "R7 hold under backpressure", wdata, vals[ec]);
      end
      ready = 1'b1;
      if (start_last && k == nw - 1) start = 1'b1;
      @(negedge clk);
      ready = 1'b0; start = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    fill(1);
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !valid && !busy && !ferr, "R1 reset state",
        {cs_n, sclk, valid, busy, ferr}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !busy, "R1 idle after reset", cs_n, 1);

    // vector table
    for (int i = 0; i < N_VEC; i++) begin
      fill(int'(VEC[i][11:0]));
      kick(VEC[i][15]);
      collect(VEC[i][15], int'(VEC[i][14:12]), 1'b0);
      chk(!ferr, "R8 clean marker", ferr, 0);
      while (!cs_n) @(negedge clk);
    end

    // R3 lead and trail timing, extreme codes
    for (int c2 = 0; c2 < NUM_CH; c2++) vals[c2] = (c2 % 2) ? 14'h3fff : 14'h0000;
    @(negedge clk);
    single = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!sclk && c < 100) begin @(negedge clk); c++; end
    chk(c == 2 * HALF, "R3 cs fall to first sclk rise", c, 2 * HALF);
    collect(1'b0, 0, 1'b0);
    c = 0;
    while (!cs_n && c < 100) begin @(negedge clk); c++; end
    chk(c == HALF, "R3 final accept to cs rise", c, HALF);

    // R9 start while busy, in drain, ignored
    fill(77);
    kick(1'b1);
    while (!valid) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect(1'b1, 0, 1'b0);
    while (!cs_n) @(negedge clk);
    c = 0;
    repeat (40) begin @(negedge clk); if (!cs_n || valid) c++; end
    chk(c == 0, "R9 start during readout ignored", c, 0);

    // R9 start in the same cycle as final acceptance
    fill(5);
    kick(1'b0);
    collect(1'b0, 0, 1'b1);
    c = 0;
    repeat (HALF + 40) begin @(negedge clk); if (valid || (cs_n == 1'b0 && c < 0)) c++; end
    chk(cs_n && !busy, "R9 start on last accept ignored", cs_n, 1);
    chk(c == 0, "R9 no words after last accept", c, 0);

    // R8 marker low at frame start
    fd_mode = 1;
    fill(9);
    kick(1'b0);
    collect(1'b0, 0, 1'b0);
    chk(ferr, "R8 marker low at start", ferr, 1);
    while (!cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(ferr, "R8 error held when idle", ferr, 1);

    // R8 marker never drops
    fd_mode = 2;
    kick(1'b1);
    @(negedge clk);
    chk(!ferr, "R8 error cleared on start", ferr, 0);
    collect(1'b1, 0, 1'b0);
    chk(ferr, "R8 marker stuck high", ferr, 1);
    while (!cs_n) @(negedge clk);

    // R6 line B ignored: same words regardless of its value
    fd_mode = 0;
    fill(321);
    kick(1'b1);
    collect(1'b1, 1, 1'b0);
    chk(!ferr, "R8 recovery clean", ferr, 0);
    while (!cs_n) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule